// File: doc/BRIEF.md
# Lazy Register Checkpoint Unit

This block keeps a rollback copy of a thread's vector registers while that thread runs a speculative region. It copies nothing when the region opens. It only clears a per-thread "saved" bit-vector, with one bit for each architectural register. The first time the thread writes a register whose bit is still clear, the block holds the write back for one cycle and copies the old contents into a dedicated save RAM. It then sets the bit. The write lands in the next cycle. Later writes to the same register in the same region go straight through.

A commit throws the checkpoint away in a single cycle. An abort starts a restore engine. The engine visits only the registers whose bits are set, from the lowest register number upward, one per cycle, and writes each saved value back. It signals completion once the vector is empty. Each of several hardware threads has its own independent region state. The register file and the save RAM are simple behavioural models inside the block.

Top module: `ckpt_lazy_unit`

## Requirements
- R1: After reset, no thread is speculating (`spec_active` is all zero), `restore_done` is low, and `wr_ready` is high while no request is presented.
- R2: A start request for a non-speculating thread makes that thread speculative in the next cycle with an empty saved set. No register is copied and no write stalls because of the start itself.
- R3: During speculation, a write to a register not yet saved sees `wr_ready` low for exactly one cycle while the old value is copied to the save RAM. The write then lands with its new data.
- R4: A write to a register that was already saved in the current region never stalls.
- R5: Writes from a thread that is not speculating never stall and never cause a save.
- R6: An abort restores every saved register to the value it held before its first write in the region, and leaves every other register unchanged. Restore writes back one register per cycle in ascending register order. With k saved registers, `restore_done` is high in the k-th cycle after the abort cycle, counting that next cycle as cycle 0. In the cycle after that, the thread is no longer speculating.
- R7: While a restore is running, `wr_ready` is low for every thread, and start, commit and abort requests have no effect.
- R8: A commit ends the region in one cycle. Register values stay as last written, and the thread's saved set becomes empty.
- R9: A start request for a thread that is already speculating is ignored. Its saved set is kept, so a register saved before the request is not saved again.
- R10: Commit or abort for a thread that is not speculating is ignored, and `restore_done` stays low.
- R11: Each thread's region state is independent. An abort of one thread never changes another thread's registers or region.
- R12: In any cycle where a start, commit or abort input is high, `wr_ready` is low. A write held back that way is judged against the region state after the request takes effect. Among several request inputs high at once, abort has priority over commit, and commit over start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_start | input | 1 | Open a speculative region for `ctl_thr` |
| ctl_commit | input | 1 | Commit the region of `ctl_thr` |
| ctl_abort | input | 1 | Abort the region of `ctl_thr` and roll back |
| ctl_thr | input | 2 | Thread selected by the control request |
| wr_valid | input | 1 | Register write request |
| wr_thr | input | 2 | Thread of the write |
| wr_reg | input | 5 | Register number of the write |
| wr_data | input | 512 | New register value |
| wr_ready | output | 1 | Write accepted at this clock edge |
| rd_thr | input | 2 | Thread of the observation read |
| rd_reg | input | 5 | Register number of the observation read |
| rd_data | output | 512 | Current register value, combinational |
| spec_active | output | 4 | Per-thread speculating flag |
| restore_done | output | 1 | High for one cycle when an abort restore has finished |

## Verification
Two functions can fall in the same cycle: a register write and a control request. Either the write lands together with a commit, or a first-time write meets an abort of its own thread. The bench provokes both by holding a write to an unsaved register at the port while it raises the commit or abort input. With commit, the write must stall only during the request cycle and then land without a save. With abort, the write must stay blocked through every restore cycle and the done cycle, then land without a save, and the earlier saved register must come back. A third overlap is a start request and a write for another thread presented in the middle of a restore. Both must be refused.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  localparam int CK_THREADS = 4;
  localparam int CK_REGS    = 32;
  localparam int CK_DW      = 512;

  typedef enum logic {ST_IDLE, ST_RESTORE} ck_state_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic int flat_idx(input int t, input int r, input int nreg);
    return t * nreg + r;
  endfunction
endpackage

// File: rtl/ckpt_rf.sv
module ckpt_rf
  import ckpt_pkg::*;
#(
  parameter int NTHR = CK_THREADS,
  parameter int NREG = CK_REGS,
  parameter int DW   = CK_DW,
  localparam int TW  = idx_w(NTHR),
  localparam int RW  = idx_w(NREG),
  localparam int DEPTH = NTHR * NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [TW-1:0] w_thr,
  input  logic [RW-1:0] w_reg,
  input  logic [DW-1:0] w_data,
  input  logic [TW-1:0] a_thr,
  input  logic [RW-1:0] a_reg,
  output logic [DW-1:0] a_data,
  input  logic [TW-1:0] b_thr,
  input  logic [RW-1:0] b_reg,
  output logic [DW-1:0] b_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[flat_idx(int'(w_thr), int'(w_reg), NREG)] <= w_data;
    end
  end

  assign a_data = mem[flat_idx(int'(a_thr), int'(a_reg), NREG)];
  assign b_data = mem[flat_idx(int'(b_thr), int'(b_reg), NREG)];
endmodule

// File: rtl/ckpt_save_ram.sv
module ckpt_save_ram
  import ckpt_pkg::*;
#(
  parameter int NTHR = CK_THREADS,
  parameter int NREG = CK_REGS,
  parameter int DW   = CK_DW,
  localparam int TW  = idx_w(NTHR),
  localparam int RW  = idx_w(NREG),
  localparam int DEPTH = NTHR * NREG
) (
  input  logic          clk,
  input  logic          we,
  input  logic [TW-1:0] w_thr,
  input  logic [RW-1:0] w_reg,
  input  logic [DW-1:0] w_data,
  input  logic [TW-1:0] r_thr,
  input  logic [RW-1:0] r_reg,
  output logic [DW-1:0] r_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[flat_idx(int'(w_thr), int'(w_reg), NREG)] <= w_data;
  end

  assign r_data = mem[flat_idx(int'(r_thr), int'(r_reg), NREG)];
endmodule

// File: rtl/ckpt_track.sv
module ckpt_track
  import ckpt_pkg::*;
#(
  parameter int NTHR = CK_THREADS,
  parameter int NREG = CK_REGS,
  localparam int TW  = idx_w(NTHR),
  localparam int RW  = idx_w(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_en,
  input  logic [TW-1:0]             start_thr,
  input  logic                      end_en,
  input  logic [TW-1:0]             end_thr,
  input  logic                      set_en,
  input  logic [TW-1:0]             set_thr,
  input  logic [RW-1:0]             set_reg,
  input  logic                      clr_en,
  input  logic [TW-1:0]             clr_thr,
  input  logic [RW-1:0]             clr_reg,
  input  logic [TW-1:0]             scan_thr,
  output logic [NTHR-1:0]           active,
  output logic [NTHR-1:0][NREG-1:0] saved,
  output logic                      scan_any,
  output logic [RW-1:0]             scan_idx
);
  function automatic logic [RW-1:0] lowest_set(input logic [NREG-1:0] v);
    logic [RW-1:0] idx;
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) if (v[i]) idx = RW'(i);
    return idx;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
      saved  <= '0;
    end else begin
      if (set_en) saved[set_thr][set_reg] <= 1'b1;
      if (clr_en) saved[clr_thr][clr_reg] <= 1'b0;
      if (start_en) begin
        active[start_thr] <= 1'b1;
        saved[start_thr]  <= '0;
      end
      if (end_en) begin
        active[end_thr] <= 1'b0;
        saved[end_thr]  <= '0;
      end
    end
  end

  assign scan_any = |saved[scan_thr];
  assign scan_idx = lowest_set(saved[scan_thr]);

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_en |=> active[$past(start_thr)] && (saved[$past(start_thr)] == '0));
  // R3
  save_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> saved[$past(set_thr)][$past(set_reg)]);
  // R6
  restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> $countones(saved[$past(clr_thr)]) == $countones($past(saved[clr_thr])) - 1);
  // R8
  end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_en |=> !active[$past(end_thr)] && (saved[$past(end_thr)] == '0));
endmodule

// File: rtl/ckpt_lazy_unit.sv
module ckpt_lazy_unit
  import ckpt_pkg::*;
#(
  parameter int NTHR = CK_THREADS,
  parameter int NREG = CK_REGS,
  parameter int DW   = CK_DW,
  localparam int TW  = idx_w(NTHR),
  localparam int RW  = idx_w(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_start,
  input  logic            ctl_commit,
  input  logic            ctl_abort,
  input  logic [TW-1:0]   ctl_thr,
  input  logic            wr_valid,
  input  logic [TW-1:0]   wr_thr,
  input  logic [RW-1:0]   wr_reg,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_ready,
  input  logic [TW-1:0]   rd_thr,
  input  logic [RW-1:0]   rd_reg,
  output logic [DW-1:0]   rd_data,
  output logic [NTHR-1:0] spec_active,
  output logic            restore_done
);
  ck_state_e state_q;
  logic [TW-1:0] rthr_q;

  logic [NTHR-1:0]           active;
  logic [NTHR-1:0][NREG-1:0] saved;
  logic                      scan_any;
  logic [RW-1:0]             scan_idx;
  logic [DW-1:0]             old_val, save_val;

  // named internal events
  logic restoring, any_ctl, ctl_ok;
  logic abort_fire, commit_fire, start_fire, start_dup;
  logic need_save, wr_fire, rest_step, end_en;
  logic [TW-1:0] end_thr;

  assign restoring   = (state_q == ST_RESTORE);
  assign any_ctl     = ctl_start | ctl_commit | ctl_abort;
  assign ctl_ok      = any_ctl && !restoring;
  assign abort_fire  = ctl_ok && ctl_abort && active[ctl_thr];
  assign commit_fire = ctl_ok && !ctl_abort && ctl_commit && active[ctl_thr];
  assign start_fire  = ctl_ok && !ctl_abort && !ctl_commit && ctl_start && !active[ctl_thr];
  assign start_dup   = ctl_ok && !ctl_abort && !ctl_commit && ctl_start && active[ctl_thr];

  assign need_save = wr_valid && !restoring && !any_ctl
                     && active[wr_thr] && !saved[wr_thr][wr_reg];
  assign wr_ready  = !restoring && !any_ctl && !need_save;
  assign wr_fire   = wr_valid && wr_ready;

  assign rest_step    = restoring && scan_any;
  assign restore_done = restoring && !scan_any;
  assign end_en       = commit_fire || restore_done;
  assign end_thr      = restore_done ? rthr_q : ctl_thr;
  assign spec_active  = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rthr_q  <= '0;
    end else if (abort_fire) begin
      state_q <= ST_RESTORE;
      rthr_q  <= ctl_thr;
    end else if (restore_done) begin
      state_q <= ST_IDLE;
    end
  end

  ckpt_track #(.NTHR(NTHR), .NREG(NREG)) u_track (
    .clk(clk), .rst_n(rst_n),
    .start_en(start_fire), .start_thr(ctl_thr),
    .end_en(end_en), .end_thr(end_thr),
    .set_en(need_save), .set_thr(wr_thr), .set_reg(wr_reg),
    .clr_en(rest_step), .clr_thr(rthr_q), .clr_reg(scan_idx),
    .scan_thr(rthr_q),
    .active(active), .saved(saved),
    .scan_any(scan_any), .scan_idx(scan_idx)
  );

  ckpt_rf #(.NTHR(NTHR), .NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(wr_fire || rest_step),
    .w_thr(rest_step ? rthr_q : wr_thr),
    .w_reg(rest_step ? scan_idx : wr_reg),
    .w_data(rest_step ? save_val : wr_data),
    .a_thr(wr_thr), .a_reg(wr_reg), .a_data(old_val),
    .b_thr(rd_thr), .b_reg(rd_reg), .b_data(rd_data)
  );

  ckpt_save_ram #(.NTHR(NTHR), .NREG(NREG), .DW(DW)) u_save (
    .clk(clk),
    .we(need_save), .w_thr(wr_thr), .w_reg(wr_reg), .w_data(old_val),
    .r_thr(rthr_q), .r_reg(scan_idx), .r_data(save_val)
  );

  // R4
  wr_land_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && active[wr_thr]) |-> saved[wr_thr][wr_reg]);
  // R9
  start_dup_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_dup |=> $stable(saved) && $stable(active));
  // R7
  restore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restoring && scan_any) |=> restoring && (rthr_q == $past(rthr_q)));
endmodule

// File: tb/ckpt_lazy_unit_tb.sv
module ckpt_lazy_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int NR = 32;
  localparam int DW = 512;

  logic clk = 0, rst_n = 0;
  logic ctl_start = 0, ctl_commit = 0, ctl_abort = 0;
  logic [1:0] ctl_thr = 0;
  logic wr_valid = 0;
  logic [1:0] wr_thr = 0;
  logic [4:0] wr_reg = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready;
  logic [1:0] rd_thr = 0;
  logic [4:0] rd_reg = 0;
  logic [DW-1:0] rd_data;
  logic [NT-1:0] spec_active;
  logic restore_done;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model of the requirements
  logic [DW-1:0] m_rf [NT][NR];
  logic [DW-1:0] m_sv [NT][NR];
  bit m_bits [NT][NR];
  bit m_act [NT];

  typedef struct { int t; int r; logic [DW-1:0] d; string req; } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ckpt_lazy_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_start(ctl_start), .ctl_commit(ctl_commit), .ctl_abort(ctl_abort), .ctl_thr(ctl_thr),
    .wr_valid(wr_valid), .wr_thr(wr_thr), .wr_reg(wr_reg), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_thr(rd_thr), .rd_reg(rd_reg), .rd_data(rd_data),
    .spec_active(spec_active), .restore_done(restore_done)
  );

  function automatic logic [DW-1:0] pat(input int g, input int t, input int r);
    return {16{32'(g * 4096 + t * 256 + r)}};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      rd_thr = 2'(it.t);
      rd_reg = 5'(it.r);
      #1;
      total++;
      if (rd_data !== it.d) begin
        bad++;
        $display("FAIL %s t%0d r%0d actual=%h expected=%h", it.req, it.t, it.r,
                 rd_data[31:0], it.d[31:0]);
      end
    end
  end

  task automatic expect_reg(input int t, input int r, input string req);
    item_t it;
    it.t = t; it.r = r; it.d = m_rf[t][r]; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: write with stall counting against the model
  task automatic do_wr(input int t, input int r, input logic [DW-1:0] d, input string req);
    int n, e;
    e = (m_act[t] && !m_bits[t][r]) ? 1 : 0;
    if (e == 1) begin m_sv[t][r] = m_rf[t][r]; m_bits[t][r] = 1; end
    m_rf[t][r] = d;
    wr_valid = 1; wr_thr = 2'(t); wr_reg = 5'(r); wr_data = d;
    n = 0;
    #1;
    while (!wr_ready && n < 50) begin n++; @(negedge clk); #1; end
    @(negedge clk);
    wr_valid = 0;
    chk(n == e, req, n, e);
  endtask

  task automatic model_abort(input int t, output int k);
    k = 0;
    for (int r = 0; r < NR; r++) if (m_bits[t][r]) begin
      k++; m_rf[t][r] = m_sv[t][r]; m_bits[t][r] = 0;
    end
    m_act[t] = 0;
  endtask

  task automatic wait_done(input int k, input string req);
    int n;
    n = 0;
    #1;
    while (!restore_done && n < 100) begin n++; @(negedge clk); #1; end
    chk(n == k, req, n, k);
    @(negedge clk);
  endtask

  task automatic do_ctl(input int op, input int t);
    int k;
    ctl_thr = 2'(t);
    if (op == 0) ctl_start = 1; else if (op == 1) ctl_commit = 1; else ctl_abort = 1;
    @(negedge clk);
    ctl_start = 0; ctl_commit = 0; ctl_abort = 0;
    if (op == 0) begin
      if (!m_act[t]) begin m_act[t] = 1; for (int r = 0; r < NR; r++) m_bits[t][r] = 0; end
    end else if (op == 1) begin
      if (m_act[t]) begin m_act[t] = 0; for (int r = 0; r < NR; r++) m_bits[t][r] = 0; end
    end else begin
      if (m_act[t]) begin
        model_abort(t, k);
        wait_done(k, "R6 restore cycles");
      end else begin
        // R10: nothing starts
        #1; chk(restore_done == 0, "R10 abort idle thread", int'(restore_done), 0);
        @(negedge clk); #1;
        chk(restore_done == 0, "R10 abort idle thread", int'(restore_done), 0);
      end
    end
  endtask

  task automatic chk_act(input string req);
    #1;
    for (int t = 0; t < NT; t++)
      chk(spec_active[t] == m_act[t], req, int'(spec_active[t]), int'(m_act[t]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k, n;
    for (int t = 0; t < NT; t++) begin
      m_act[t] = 0;
      for (int r = 0; r < NR; r++) begin m_rf[t][r] = '0; m_bits[t][r] = 0; m_sv[t][r] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(spec_active == 0, "R1 spec_active", int'(spec_active), 0);
    chk(restore_done == 0, "R1 restore_done", int'(restore_done), 0);
    chk(wr_ready == 1, "R1 wr_ready", int'(wr_ready), 1);
    @(negedge clk);

    // R5: fill regs outside speculation, no stalls
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < 12; r++) do_wr(t, r, pat(1, t, r), "R5 plain write stall");
    do_wr(0, 31, pat(1, 0, 31), "R5 plain write stall");
    expect_reg(0, 31, "R5 plain value"); expect_reg(3, 11, "R5 plain value");
    drain();

    // R2/R3/R4 on thread 0
    do_ctl(0, 0); chk_act("R2 start active");
    do_wr(0, 5, pat(2, 0, 5), "R3 first write stall");
    do_wr(0, 5, pat(3, 0, 5), "R4 repeat write no stall");
    do_wr(0, 2, pat(2, 0, 2), "R3 first write stall");
    do_wr(0, 31, pat(2, 0, 31), "R3 first write stall");
    expect_reg(0, 5, "R3 new value"); expect_reg(0, 31, "R3 new value");
    drain();
    // R10 commit on idle thread 1 is ignored
    do_ctl(1, 1); chk_act("R10 commit idle thread");
    do_ctl(2, 0); chk_act("R6 inactive after abort");
    expect_reg(0, 2, "R6 restored"); expect_reg(0, 5, "R6 restored");
    expect_reg(0, 31, "R6 restored"); expect_reg(0, 7, "R6 untouched");
    drain();
    do_ctl(2, 2); // R10 abort idle thread

    // R8 commit keeps values
    do_ctl(0, 1);
    do_wr(1, 0, pat(4, 1, 0), "R3 first write stall");
    do_ctl(1, 1); chk_act("R8 commit ends region");
    do_wr(1, 0, pat(5, 1, 0), "R5 write after commit");
    expect_reg(1, 0, "R8 value kept");
    drain();

    // R9 nested start ignored
    do_ctl(0, 2);
    do_wr(2, 3, pat(6, 2, 3), "R3 first write stall");
    do_ctl(0, 2);
    do_wr(2, 3, pat(7, 2, 3), "R9 nested start keeps saved set");
    do_ctl(2, 2);
    expect_reg(2, 3, "R9 restore to outer value");
    drain();

    // R11 independence of threads 0 and 3
    do_ctl(0, 0); do_ctl(0, 3);
    do_wr(0, 8, pat(8, 0, 8), "R3 first write stall");
    do_wr(3, 8, pat(8, 3, 8), "R3 first write stall");
    do_ctl(2, 3); chk_act("R11 other thread still active");
    expect_reg(0, 8, "R11 other thread kept"); expect_reg(3, 8, "R11 aborted thread restored");
    drain();
    do_ctl(1, 0);

    // R6 empty saved set: done in cycle 0
    do_ctl(0, 1); do_ctl(2, 1);

    // R7 requests during restore are refused
    do_ctl(0, 0);
    do_wr(0, 1, pat(9, 0, 1), "R3 first write stall");
    do_wr(0, 4, pat(9, 0, 4), "R3 first write stall");
    do_wr(0, 9, pat(9, 0, 9), "R3 first write stall");
    ctl_thr = 0; ctl_abort = 1;
    @(negedge clk);
    ctl_abort = 0;
    model_abort(0, k);
    ctl_start = 1; ctl_thr = 3; wr_valid = 1; wr_thr = 3; wr_reg = 6; wr_data = pat(9, 3, 6);
    #1; chk(wr_ready == 0, "R7 write refused in restore", int'(wr_ready), 0);
    @(negedge clk);
    ctl_start = 0; wr_valid = 0;
    n = 1;
    #1;
    while (!restore_done && n < 100) begin n++; @(negedge clk); #1; end
    chk(n == k, "R7 restore cycles", n, k);
    @(negedge clk);
    chk_act("R7 start ignored in restore");
    expect_reg(3, 6, "R7 write did not land"); expect_reg(0, 4, "R6 restored");
    drain();

    // R12 write meets commit in same cycle
    do_ctl(0, 2);
    do_wr(2, 9, pat(10, 2, 9), "R3 first write stall");
    ctl_thr = 2; ctl_commit = 1; wr_valid = 1; wr_thr = 2; wr_reg = 10; wr_data = pat(10, 2, 10);
    #1; chk(wr_ready == 0, "R12 write blocked by commit", int'(wr_ready), 0);
    @(negedge clk); ctl_commit = 0;
    #1; chk(wr_ready == 1, "R12 write after commit no save", int'(wr_ready), 1);
    @(negedge clk); wr_valid = 0;
    m_act[2] = 0; for (int r = 0; r < NR; r++) m_bits[2][r] = 0;
    m_rf[2][10] = pat(10, 2, 10);
    expect_reg(2, 10, "R12 value after commit"); expect_reg(2, 9, "R8 committed value");
    drain();

    // R12 first-time write meets abort in same cycle
    do_ctl(0, 2);
    do_wr(2, 9, pat(11, 2, 9), "R3 first write stall");
    ctl_thr = 2; ctl_abort = 1; wr_valid = 1; wr_thr = 2; wr_reg = 10; wr_data = pat(11, 2, 10);
    #1;
    n = 0;
    while (!wr_ready && n < 50) begin
      n++; @(negedge clk); ctl_abort = 0; #1;
    end
    @(negedge clk); wr_valid = 0;
    model_abort(2, k);
    m_rf[2][10] = pat(11, 2, 10);
    chk(n == k + 2, "R12 write held through abort restore", n, k + 2);
    chk_act("R12 thread inactive after abort");
    expect_reg(2, 9, "R12 saved reg restored"); expect_reg(2, 10, "R12 write landed after restore");
    drain();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule